// File: doc/BRIEF.md
# Dual-Rank DRAM Command Decoder

This block sits on the memory side of a package that holds two independently selected ranks sharing one command and address bus. On every rising clock edge it samples the per-rank active-low chip selects, the three active-low command lines, the bank address and the address bus. It turns that sample into one-cycle strobes per rank: activate, read, write, precharge, refresh and mode-register load. It also registers the fields that go with each command.

Each rank keeps its own burst-length setting, written by mode-register loads aimed at register 0. Reads and writes take their auto-precharge bit and, where the rank allows it, their burst-chop bit from the address bus on the fly. Only mode-register loads and refreshes may reach both ranks at once. Any other command that selects more than one rank is refused and flagged. All outputs are registered, so a command sampled at edge k shows on the outputs just after edge k.

Top module: `dram_rank_cmd_decoder`

## Requirements
- R1: A rank whose chip select is sampled high receives no strobe; with every chip select high, all strobes and the error flag stay low and `idle_o` is high in the following cycle.
- R2: With a rank's chip select low, {ras_n,cas_n,we_n} decodes as 000 mode load, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read; the matching strobe bit of that rank is high for exactly the cycle after the sampling edge.
- R3: For any issued strobe, `bank_o` takes the bank address and `addr_o` takes the full address bus (row for activate, op-code for mode load); both hold their value when nothing is issued.
- R4: For a read or write, `col_o` is {A11, A9..A0} in the x4 variant (A9..A0 in the x8 variant) and `auto_pre_o` equals A10; `auto_pre_o` is low for all other commands.
- R5: For a precharge, `pre_all_o` equals A10 (1 = all banks, 0 = the bank on `bank_o`); it is low for every other command.
- R6: Each rank holds a 2-bit burst mode, reset to 00, shown on `bmode_o[2r+1:2r]`. It is rewritten from A1..A0 only by a mode load with bank address bits [1:0] = 00 that reaches that rank; loads to registers 1 to 3 leave it unchanged.
- R7: On a read or write, `burst8_o` is 1 for burst length 8 and 0 for chop 4. Mode 01 (on the fly) takes A12. Mode 10 gives 0. Modes 00 and 11 give 1, and A12 is ignored in those modes.
- R8: On a mode load, `mr_sel_o` takes bank address bits [1:0], naming the register 0 to 3, and holds it otherwise.
- R9: With more than one chip select low, a mode load or refresh strobes every selected rank. An activate, read, write or precharge raises `err_o` for one cycle and issues no strobe.
- R10: Codes 110 and 111 (no operation) issue no strobe and raise no error, for any chip-select pattern.
- R11: After reset all strobes, fields and flags are 0, `idle_o` is 1 and every burst mode is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge samples |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | NUM_RANKS | Per-rank chip select, active low |
| ras_n | input | 1 | Command line, active low |
| cas_n | input | 1 | Command line, active low |
| we_n | input | 1 | Command line, active low |
| ba | input | BANK_W | Bank address / mode register index |
| addr | input | ADDR_W | Address bus |
| act_o | output | NUM_RANKS | Activate strobe per rank |
| rd_o | output | NUM_RANKS | Read strobe per rank |
| wr_o | output | NUM_RANKS | Write strobe per rank |
| pre_o | output | NUM_RANKS | Precharge strobe per rank |
| ref_o | output | NUM_RANKS | Refresh strobe per rank |
| mrs_o | output | NUM_RANKS | Mode-register load strobe per rank |
| bank_o | output | BANK_W | Bank of the last issued command |
| addr_o | output | ADDR_W | Row or op-code of the last issued command |
| col_o | output | COL_W | Column of the last issued command |
| auto_pre_o | output | 1 | Auto-precharge with the current read/write |
| burst8_o | output | 1 | Burst length 8 (1) or chop 4 (0) for the current read/write |
| pre_all_o | output | 1 | Current precharge targets all banks |
| mr_sel_o | output | 2 | Mode register index of the last load |
| err_o | output | 1 | Illegal multi-rank command seen |
| idle_o | output | 1 | No command issued this cycle |
| bmode_o | output | 2*NUM_RANKS | Burst mode held per rank |

## Verification
The embedded assertions watch the cycle-level rules on every clock. A fully deselected bus yields no strobe. At most one rank carries an activate, read, write or precharge. The error flag never coincides with such a strobe. The all-banks flag appears only with a precharge. A rank in fixed chop-4 mode never reports length 8. A burst mode changes only when its rank takes a register-0 load. The bench's reference model is needed to show the values the assertions cannot: the exact command table, the column bit mapping, the A12 and A10 values on each access, that register 1 to 3 loads leave the burst mode alone, and that both ranks receive a broadcast load. A long run of random cycles, compared every clock, exercises the mix of chip-select patterns and mode changes.

// File: rtl/drc_pkg.sv
package drc_pkg;
   // command code is {ras_n, cas_n, we_n} with the rank selected
   typedef enum logic [2:0] {
      CMD_MRS = 3'b000,
      CMD_REF = 3'b001,
      CMD_PRE = 3'b010,
      CMD_ACT = 3'b011,
      CMD_WR  = 3'b100,
      CMD_RD  = 3'b101,
      CMD_RSV = 3'b110,
      CMD_NOP = 3'b111
   } cmd_e;

   // burst mode held per rank, loaded from op-code bits [1:0] of register 0
   typedef enum logic [1:0] {
      BM_FIX8 = 2'b00,
      BM_OTF  = 2'b01,
      BM_FIX4 = 2'b10,
      BM_RSV  = 2'b11
   } bmode_e;

   localparam int MR_IDX_W = 2;
endpackage

// File: rtl/drc_cmd_class.sv
module drc_cmd_class
   import drc_pkg::*;
#(
   parameter int NUM_RANKS = 2
) (
   input  logic [NUM_RANKS-1:0] cs_n,
   input  logic                 ras_n,
   input  logic                 cas_n,
   input  logic                 we_n,
   output cmd_e                 cmd,
   output logic [NUM_RANKS-1:0] grant,
   output logic                 multi_err,
   output logic                 is_rdwr,
   output logic                 is_pre
);
   logic [NUM_RANKS-1:0] sel;
   logic                 many;
   logic                 bcast_ok;
   logic                 single_only;

   always_comb begin
      cmd         = cmd_e'({ras_n, cas_n, we_n});
      sel         = ~cs_n;
      many        = ($countones(sel) > 1);
      bcast_ok    = (cmd == CMD_MRS) || (cmd == CMD_REF);
      single_only = (cmd == CMD_ACT) || (cmd == CMD_PRE) ||
                    (cmd == CMD_RD)  || (cmd == CMD_WR);
      multi_err   = many && single_only;
      grant       = (many && !bcast_ok) ? '0 : sel;
      is_rdwr     = (cmd == CMD_RD) || (cmd == CMD_WR);
      is_pre      = (cmd == CMD_PRE);
   end
endmodule

// File: rtl/drc_addr_split.sv
module drc_addr_split #(
   parameter int ADDR_W  = 15,
   parameter bit WIDE_X4 = 1'b1,
   localparam int COL_W  = WIDE_X4 ? 11 : 10
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [COL_W-1:0]  col,
   output logic              ap_bit,
   output logic              chop_bit
);
   assign ap_bit   = addr[10];
   assign chop_bit = addr[12];

   generate
      if (WIDE_X4) begin : g_x4
         assign col = {addr[11], addr[9:0]};
      end else begin : g_x8
         assign col = addr[9:0];
      end
   endgenerate
endmodule

// File: rtl/drc_mode_reg.sv
module drc_mode_reg
   import drc_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   load_en,
   input  bmode_e new_mode,
   output bmode_e mode_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_q <= BM_FIX8;
      else if (load_en) mode_q <= new_mode;
   end

   // R6: burst mode only moves on a register-0 load to this rank
   a_r6_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load_en |=> $stable(mode_q));
endmodule

// File: rtl/dram_rank_cmd_decoder.sv
module dram_rank_cmd_decoder
   import drc_pkg::*;
#(
   parameter int  NUM_RANKS = 2,
   parameter int  BANK_W    = 3,
   parameter int  ADDR_W    = 15,
   parameter bit  WIDE_X4   = 1'b1,
   localparam int COL_W     = WIDE_X4 ? 11 : 10
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_RANKS-1:0]   cs_n,
   input  logic                   ras_n,
   input  logic                   cas_n,
   input  logic                   we_n,
   input  logic [BANK_W-1:0]      ba,
   input  logic [ADDR_W-1:0]      addr,
   output logic [NUM_RANKS-1:0]   act_o,
   output logic [NUM_RANKS-1:0]   rd_o,
   output logic [NUM_RANKS-1:0]   wr_o,
   output logic [NUM_RANKS-1:0]   pre_o,
   output logic [NUM_RANKS-1:0]   ref_o,
   output logic [NUM_RANKS-1:0]   mrs_o,
   output logic [BANK_W-1:0]      bank_o,
   output logic [ADDR_W-1:0]      addr_o,
   output logic [COL_W-1:0]       col_o,
   output logic                   auto_pre_o,
   output logic                   burst8_o,
   output logic                   pre_all_o,
   output logic [1:0]             mr_sel_o,
   output logic                   err_o,
   output logic                   idle_o,
   output logic [2*NUM_RANKS-1:0] bmode_o
);
   // elaboration-time parameter checks
   if (NUM_RANKS < 1) begin : g_chk_ranks
      $error("NUM_RANKS must be at least 1");
   end
   if (ADDR_W < 13) begin : g_chk_addr
      $error("ADDR_W must reach the chop bit (>= 13)");
   end
   if (BANK_W < MR_IDX_W) begin : g_chk_bank
      $error("BANK_W must cover the mode register index");
   end

   cmd_e                 cmd;
   logic [NUM_RANKS-1:0] grant;
   logic                 multi_err;
   logic                 is_rdwr;
   logic                 is_pre;
   logic [COL_W-1:0]     col;
   logic                 ap_bit;
   logic                 chop_bit;
   bmode_e               mode_q [NUM_RANKS];
   logic [NUM_RANKS-1:0] mr0_load;

   logic [NUM_RANKS-1:0] act_d, rd_d, wr_d, pre_d, ref_d, mrs_d;
   logic                 any_d;
   logic                 b8_d;

   drc_cmd_class #(.NUM_RANKS(NUM_RANKS)) u_class (
      .cs_n      (cs_n),
      .ras_n     (ras_n),
      .cas_n     (cas_n),
      .we_n      (we_n),
      .cmd       (cmd),
      .grant     (grant),
      .multi_err (multi_err),
      .is_rdwr   (is_rdwr),
      .is_pre    (is_pre)
   );

   drc_addr_split #(.ADDR_W(ADDR_W), .WIDE_X4(WIDE_X4)) u_split (
      .addr     (addr),
      .col      (col),
      .ap_bit   (ap_bit),
      .chop_bit (chop_bit)
   );

   for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
      assign mr0_load[r] = mrs_d[r] && (ba[MR_IDX_W-1:0] == '0);

      drc_mode_reg u_mode (
         .clk      (clk),
         .rst_n    (rst_n),
         .load_en  (mr0_load[r]),
         .new_mode (bmode_e'(addr[1:0])),
         .mode_q   (mode_q[r])
      );

      assign bmode_o[2*r +: 2] = mode_q[r];

      // R7: a rank fixed at chop 4 never reports length 8
      a_r7_fixed_chop: assert property (@(posedge clk) disable iff (!rst_n)
         (!cs_n[r] && ($countones(~cs_n) == 1) && !ras_n && cas_n == 1'b0 ? 1'b0 :
          (!cs_n[r] && ($countones(~cs_n) == 1) && ras_n && !cas_n && mode_q[r] == BM_FIX4))
         |=> !burst8_o);
   end

   always_comb begin
      act_d = grant & {NUM_RANKS{cmd == CMD_ACT}};
      rd_d  = grant & {NUM_RANKS{cmd == CMD_RD}};
      wr_d  = grant & {NUM_RANKS{cmd == CMD_WR}};
      pre_d = grant & {NUM_RANKS{cmd == CMD_PRE}};
      ref_d = grant & {NUM_RANKS{cmd == CMD_REF}};
      mrs_d = grant & {NUM_RANKS{cmd == CMD_MRS}};
      any_d = |(act_d | rd_d | wr_d | pre_d | ref_d | mrs_d);
   end

   // burst length for the single granted rank of a read or write
   always_comb begin
      b8_d = 1'b0;
      for (int r = 0; r < NUM_RANKS; r++) begin
         if (grant[r] && is_rdwr) begin
            unique case (mode_q[r])
               BM_OTF:  b8_d = chop_bit;
               BM_FIX4: b8_d = 1'b0;
               default: b8_d = 1'b1;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_o      <= '0;
         rd_o       <= '0;
         wr_o       <= '0;
         pre_o      <= '0;
         ref_o      <= '0;
         mrs_o      <= '0;
         bank_o     <= '0;
         addr_o     <= '0;
         col_o      <= '0;
         auto_pre_o <= 1'b0;
         burst8_o   <= 1'b0;
         pre_all_o  <= 1'b0;
         mr_sel_o   <= '0;
         err_o      <= 1'b0;
         idle_o     <= 1'b1;
      end else begin
         act_o      <= act_d;
         rd_o       <= rd_d;
         wr_o       <= wr_d;
         pre_o      <= pre_d;
         ref_o      <= ref_d;
         mrs_o      <= mrs_d;
         err_o      <= multi_err;
         idle_o     <= !any_d && !multi_err;
         auto_pre_o <= (|(rd_d | wr_d)) && ap_bit;
         burst8_o   <= (|(rd_d | wr_d)) && b8_d;
         pre_all_o  <= (|pre_d) && is_pre && ap_bit;
         if (any_d) begin
            bank_o <= ba;
            addr_o <= addr;
            col_o  <= col;
         end
         if (|mrs_d) mr_sel_o <= ba[MR_IDX_W-1:0];
      end
   end

   // R1: a fully deselected bus issues nothing
   a_r1_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (&cs_n) |=> ((act_o | rd_o | wr_o | pre_o | ref_o | mrs_o) == '0) && !err_o);

   // R9: bank-level commands reach at most one rank
   a_r9_single_target: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(act_o | rd_o | wr_o | pre_o));

   // R9: a refused command carries no strobe
   a_r9_err_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> ((act_o | rd_o | wr_o | pre_o | ref_o | mrs_o) == '0));

   // R5: the all-banks flag only travels with a precharge
   a_r5_all_with_pre: assert property (@(posedge clk) disable iff (!rst_n)
      pre_all_o |-> (|pre_o));

   // R4: auto-precharge only travels with a read or write
   a_r4_ap_with_access: assert property (@(posedge clk) disable iff (!rst_n)
      auto_pre_o |-> (|(rd_o | wr_o)));
endmodule

// File: tb/dram_rank_cmd_decoder_tb.sv
module dram_rank_cmd_decoder_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cs_n = 2'b11;
   logic        ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [2:0]  ba = '0;
   logic [14:0] addr = '0;

   logic [1:0]  act_o, rd_o, wr_o, pre_o, ref_o, mrs_o;
   logic [2:0]  bank_o;
   logic [14:0] addr_o;
   logic [10:0] col_o;
   logic        auto_pre_o, burst8_o, pre_all_o, err_o, idle_o;
   logic [1:0]  mr_sel_o;
   logic [3:0]  bmode_o;

   int checks = 0;
   int failures = 0;

   // reference model state
   int          m_mode [2];
   logic [1:0]  e_act, e_rd, e_wr, e_pre, e_ref, e_mrs;
   logic [2:0]  e_bank;
   logic [14:0] e_addr;
   logic [10:0] e_col;
   logic        e_ap, e_b8, e_all, e_err, e_idle;
   logic [1:0]  e_msel;

   always #(CLK_PERIOD/2) clk = ~clk;

   dram_rank_cmd_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .ba(ba), .addr(addr),
      .act_o(act_o), .rd_o(rd_o), .wr_o(wr_o), .pre_o(pre_o), .ref_o(ref_o),
      .mrs_o(mrs_o), .bank_o(bank_o), .addr_o(addr_o), .col_o(col_o),
      .auto_pre_o(auto_pre_o), .burst8_o(burst8_o), .pre_all_o(pre_all_o),
      .mr_sel_o(mr_sel_o), .err_o(err_o), .idle_o(idle_o), .bmode_o(bmode_o)
   );

   task automatic chk(input string tag, input string nm, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, nm, act, exp);
      end
   endtask

   task automatic compare_all(input string tag);
      chk(tag, "act_o", act_o, e_act);
      chk(tag, "rd_o", rd_o, e_rd);
      chk(tag, "wr_o", wr_o, e_wr);
      chk(tag, "pre_o", pre_o, e_pre);
      chk(tag, "ref_o", ref_o, e_ref);
      chk(tag, "mrs_o", mrs_o, e_mrs);
      chk(tag, "bank_o", bank_o, e_bank);
      chk(tag, "addr_o", addr_o, e_addr);
      chk(tag, "col_o", col_o, e_col);
      chk(tag, "auto_pre_o", auto_pre_o, e_ap);
      chk(tag, "burst8_o", burst8_o, e_b8);
      chk(tag, "pre_all_o", pre_all_o, e_all);
      chk(tag, "mr_sel_o", mr_sel_o, e_msel);
      chk(tag, "err_o", err_o, e_err);
      chk(tag, "idle_o", idle_o, e_idle);
      chk(tag, "bmode_r0", bmode_o[1:0], m_mode[0]);
      chk(tag, "bmode_r1", bmode_o[3:2], m_mode[1]);
   endtask

   // behavioural model of one sampled command
   task automatic model(input logic [1:0] cs, input logic [2:0] c,
                        input logic [2:0] b, input logic [14:0] a);
      int nsel = 0;
      bit single, bcast, rdwr;
      logic [1:0] g;
      for (int r = 0; r < 2; r++) if (!cs[r]) nsel++;
      single = (c == 3'd2) || (c == 3'd3) || (c == 3'd4) || (c == 3'd5);
      bcast  = (c == 3'd0) || (c == 3'd1);
      rdwr   = (c == 3'd4) || (c == 3'd5);
      e_err  = (nsel > 1) && single;
      g      = e_err ? 2'b00 : ~cs;
      e_mrs  = (c == 3'd0) ? g : 2'b00;
      e_ref  = (c == 3'd1) ? g : 2'b00;
      e_pre  = (c == 3'd2) ? g : 2'b00;
      e_act  = (c == 3'd3) ? g : 2'b00;
      e_wr   = (c == 3'd4) ? g : 2'b00;
      e_rd   = (c == 3'd5) ? g : 2'b00;
      e_ap   = rdwr && (g != 0) && a[10];
      e_all  = (c == 3'd2) && (g != 0) && a[10];
      e_b8   = 1'b0;
      if (rdwr && g != 0) begin
         int m = g[0] ? m_mode[0] : m_mode[1];
         e_b8 = (m == 1) ? a[12] : ((m == 2) ? 1'b0 : 1'b1);
      end
      if (!bcast && !single) e_idle = 1'b1;
      else e_idle = (g == 0) && !e_err;
      if (bcast || single) begin
         if (g != 0) begin
            e_bank = b;
            e_addr = a;
            e_col  = {a[11], a[9:0]};
         end
      end
      if (c == 3'd0 && g != 0) begin
         e_msel = b[1:0];
         if (b[1:0] == 2'b00)
            for (int r = 0; r < 2; r++) if (g[r]) m_mode[r] = int'(a[1:0]);
      end
   endtask

   task automatic step(input logic [1:0] cs, input logic [2:0] c,
                       input logic [2:0] b, input logic [14:0] a, input string tag);
      cs_n = cs; {ras_n, cas_n, we_n} = c; ba = b; addr = a;
      @(posedge clk);
      model(cs, c, b, a);
      @(negedge clk);
      compare_all(tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      m_mode[0] = 0; m_mode[1] = 0;
      e_act = 0; e_rd = 0; e_wr = 0; e_pre = 0; e_ref = 0; e_mrs = 0;
      e_bank = 0; e_addr = 0; e_col = 0; e_ap = 0; e_b8 = 0; e_all = 0;
      e_msel = 0; e_err = 0; e_idle = 1;
      repeat (3) @(negedge clk);
      compare_all("R11");
      rst_n = 1'b1;
      @(negedge clk);
      compare_all("R11");

      step(2'b11, 3'd3, 3'd5, 15'h1234, "R1");        // deselect masks activate
      step(2'b11, 3'd0, 3'd0, 15'h0001, "R1");        // deselect masks mode load
      step(2'b10, 3'd3, 3'd6, 15'h7ABC, "R3");        // activate rank 0
      step(2'b01, 3'd3, 3'd1, 15'h0F0F, "R3");        // activate rank 1
      step(2'b10, 3'd5, 3'd2, 15'h0C55, "R4");        // read A11,A10 set
      step(2'b01, 3'd4, 3'd3, 15'h03FF, "R4");        // write no auto-precharge
      step(2'b10, 3'd2, 3'd4, 15'h0400, "R5");        // precharge all
      step(2'b01, 3'd2, 3'd7, 15'h0000, "R5");        // precharge one bank
      step(2'b10, 3'd1, 3'd0, 15'h0000, "R2");        // refresh rank 0
      step(2'b10, 3'd7, 3'd1, 15'h1111, "R10");       // nop
      step(2'b00, 3'd6, 3'd1, 15'h2222, "R10");       // reserved code, both low
      step(2'b10, 3'd5, 3'd0, 15'h0000, "R7");        // fixed BL8, A12 low ignored
      step(2'b10, 3'd0, 3'd0, 15'h0001, "R6");        // rank 0 to on-the-fly
      step(2'b10, 3'd5, 3'd0, 15'h0000, "R7");        // otf, A12 low: chop 4
      step(2'b10, 3'd4, 3'd0, 15'h1000, "R7");        // otf, A12 high: BL8
      step(2'b01, 3'd0, 3'd1, 15'h0002, "R8");        // register 1 load, no mode change
      step(2'b01, 3'd0, 3'd0, 15'h0002, "R6");        // rank 1 fixed chop 4
      step(2'b01, 3'd5, 3'd0, 15'h1000, "R7");        // fixed chop 4 ignores A12
      step(2'b00, 3'd0, 3'd0, 15'h0003, "R9");        // broadcast load, mode 11
      step(2'b10, 3'd5, 3'd0, 15'h0000, "R7");        // mode 11 acts as BL8
      step(2'b00, 3'd1, 3'd0, 15'h0000, "R9");        // broadcast refresh
      step(2'b00, 3'd3, 3'd2, 15'h0555, "R9");        // refused activate
      step(2'b00, 3'd5, 3'd2, 15'h1400, "R9");        // refused read
      step(2'b00, 3'd0, 3'd3, 15'h0001, "R8");        // broadcast register 3 load
      step(2'b10, 3'd2, 3'd1, 15'h0400, "R2");

      for (int i = 0; i < 600; i++)
         step(2'($urandom), 3'($urandom), 3'($urandom), 15'($urandom), "R2");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule